// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches sixteen interrupt lines. Each line is fed by the pin of the same number on one of several I/O ports, and a per-line source field picks the port. Each line compares its selected input with the value it held one clock earlier. A rising transition, a falling transition, or either one can qualify, as set by software. A qualifying transition does two things, each under its own enable. It can latch a sticky pending flag that drives a level interrupt request. It can also produce a one-cycle event pulse.

Software reaches the block through a 32-bit register bus. A register is written when valid and write are both high at a clock edge. Read data is combinational from the address. The pending flags are cleared by writing ones to them. The pin inputs are assumed to be synchronous to the clock already.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq_req` is zero and `evt_pulse` is zero.
- R2: Line n takes its source from the 4-bit field at bits [4*(n%4)+3 : 4*(n%4)] of the selector word at address 4*(n/4). Field value p selects bit p*16+n of `port_pins`. A field value of NUM_PORTS (4) or more makes the line a constant 0, and the stored field still reads back unchanged.
- R3: With the rising enable bit of line n set at address 0x18, a 0 to 1 change of the selected input counts as a trigger. A 1 to 0 change does not count unless R4 applies.
- R4: With the falling enable bit set at address 0x1C, a 1 to 0 change counts as a trigger. With both enable bits set, either change counts. With neither set, no change counts.
- R5: A trigger sets pending bit n (address 0x20) only while interrupt enable bit n (address 0x10) is 1. `irq_req[n]` is high while pending bit n and interrupt enable bit n are both 1. It stays high until the pending bit is cleared or the enable bit is dropped.
- R6: A trigger while event enable bit n (address 0x14) is 1 gives `evt_pulse[n]` high for exactly the one cycle after the clock edge that sampled the change. The event path never sets a pending bit.
- R7: Writing 1 to a bit at address 0x20 clears that pending bit. Writing 0 leaves it unchanged. A write there never sets a bit.
- R8: When a trigger and a clear of the same pending bit happen in the same cycle, the bit stays set.
- R9: A change of a line's selector field never counts as a trigger, even when the old and new sources differ in level. Changes on the new source count from the cycle after the field change.
- R10: Register addresses are 0x00, 0x04, 0x08 and 0x0C for the selectors, then 0x10 for the interrupt enables, 0x14 for the event enables, 0x18 for the rising enables, 0x1C for the falling enables and 0x20 for the pending flags. Bits 31:16 read 0. Any other address reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| port_pins | input | 64 | Pin levels of all ports; port p pin n at bit p*16+n |
| irq_req | output | 16 | Level interrupt request per line |
| evt_pulse | output | 16 | One-cycle event pulse per line |

## Verification
A wrong previous-value register shows up in two ways: a spurious pending bit, or a missing pending bit on the first change after a reselect. Either one appears on the pending read and on `irq_req` one clock after the offending input change. A pending flag with the wrong update priority fails the clear checks. It loses a same-cycle trigger or ignores a write of zero, and this is visible on the next read of address 0x20. A wrong selector field decode feeds the line from the wrong pin. A transition on the intended pin then leaves the line silent, and this is seen within one cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 4;
    localparam int FIELDS_PER = 4;

    localparam int OFF_IRQ_EN  = 'h10;
    localparam int OFF_EVT_EN  = 'h14;
    localparam int OFF_RISE_EN = 'h18;
    localparam int OFF_FALL_EN = 'h1C;
    localparam int OFF_PEND    = 'h20;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rise;
        logic             fall;
    } line_cfg_t;

    function automatic int sel_word_addr(input int w);
        return w * 4;
    endfunction
endpackage

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] pend_set,
    output logic [SEL_W-1:0]     sel_q [NUM_LINES],
    output logic [NUM_LINES-1:0] irq_en_q,
    output logic [NUM_LINES-1:0] evt_en_q,
    output logic [NUM_LINES-1:0] rise_en_q,
    output logic [NUM_LINES-1:0] fall_en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [DATA_W-1:0]    bus_rdata
);
    localparam int SEL_WORDS = NUM_LINES / FIELDS_PER;

    logic                 wr;
    int                   addr_i;
    logic [NUM_LINES-1:0] clr;

    assign wr     = bus_valid & bus_write;
    assign addr_i = int'(bus_addr);
    assign clr    = (wr && addr_i == OFF_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_LINES; n++) sel_q[n] <= '0;
            irq_en_q  <= '0;
            evt_en_q  <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr) begin
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (addr_i == sel_word_addr(w)) begin
                    for (int k = 0; k < FIELDS_PER; k++)
                        sel_q[w*FIELDS_PER+k] <= bus_wdata[k*SEL_W +: SEL_W];
                end
            end
            case (addr_i)
                OFF_IRQ_EN:  irq_en_q  <= bus_wdata[NUM_LINES-1:0];
                OFF_EVT_EN:  evt_en_q  <= bus_wdata[NUM_LINES-1:0];
                OFF_RISE_EN: rise_en_q <= bus_wdata[NUM_LINES-1:0];
                OFF_FALL_EN: fall_en_q <= bus_wdata[NUM_LINES-1:0];
                default: ;
            endcase
        end
    end

    // set wins over clear so a same-cycle trigger is not lost
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | pend_set;
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (addr_i == sel_word_addr(w)) begin
                for (int k = 0; k < FIELDS_PER; k++)
                    bus_rdata[k*SEL_W +: SEL_W] = sel_q[w*FIELDS_PER+k];
            end
        end
        case (addr_i)
            OFF_IRQ_EN:  bus_rdata = DATA_W'(irq_en_q);
            OFF_EVT_EN:  bus_rdata = DATA_W'(evt_en_q);
            OFF_RISE_EN: bus_rdata = DATA_W'(rise_en_q);
            OFF_FALL_EN: bus_rdata = DATA_W'(fall_en_q);
            OFF_PEND:    bus_rdata = DATA_W'(pend_q);
            default: ;
        endcase
    end
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] pins,
    input  line_cfg_t            cfg,
    output logic                 trig
);
    logic             cur;
    logic             prev_q;
    logic [SEL_W-1:0] sel_last_q;

    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (cfg.sel == SEL_W'(p)) cur = pins[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b0;
            sel_last_q <= '0;
        end else begin
            prev_q     <= cur;
            sel_last_q <= cfg.sel;
        end
    end

    // the first cycle on a new source only reloads prev_q
    assign trig = (cfg.sel == sel_last_q) &
                  ((cfg.rise & cur & ~prev_q) | (cfg.fall & ~cur & prev_q));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    output logic [NUM_LINES-1:0]           irq_req,
    output logic [NUM_LINES-1:0]           evt_pulse
);
    logic [SEL_W-1:0]     sel_q [NUM_LINES];
    logic [NUM_LINES-1:0] irq_en_q, evt_en_q, rise_en_q, fall_en_q, pend_q;
    logic [NUM_LINES-1:0] trig;
    logic [NUM_LINES-1:0] evt_q;

    extint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_set  (trig & irq_en_q),
        .sel_q     (sel_q),
        .irq_en_q  (irq_en_q),
        .evt_en_q  (evt_en_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .pend_q    (pend_q),
        .bus_rdata (bus_rdata)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic [NUM_PORTS-1:0] pins_n;
        line_cfg_t            cfg_n;
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
            assign pins_n[p] = port_pins[p*NUM_LINES + n];
        end
        assign cfg_n = '{sel: sel_q[n], rise: rise_en_q[n], fall: fall_en_q[n]};
        extint_line #(.NUM_PORTS(NUM_PORTS)) u_line (
            .clk  (clk),
            .rst  (rst),
            .pins (pins_n),
            .cfg  (cfg_n),
            .trig (trig[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= trig & evt_en_q;
    end

    assign evt_pulse = evt_q;
    assign irq_req   = pend_q & irq_en_q;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] evt_pulse,
    input logic [NUM_LINES-1:0] irq_en_q,
    input logic [NUM_LINES-1:0] evt_en_q,
    input logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] clr_mask;
    assign clr_mask = (bus_valid && bus_write && int'(bus_addr) == 'h20)
                      ? bus_wdata[NUM_LINES-1:0] : '0;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && evt_pulse == '0 && pend_q == '0));

    // R5: pending only rises on lines whose interrupt enable was set
    p_pend_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(irq_en_q)) == '0);

    // R6: an event pulse needs the event enable of the previous cycle
    p_evt_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & ~$past(evt_en_q)) == '0);

    // R7: a pending bit only falls through a write-one clear
    p_pend_clear_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0);

    // R5: the request never shows without a pending flag
    p_irq_has_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~pend_q) == '0);
endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .evt_pulse (evt_pulse),
    .irq_en_q  (irq_en_q),
    .evt_en_q  (evt_en_q),
    .pend_q    (pend_q)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pins = '0;
    logic [15:0] irq_req;
    logic [15:0] evt_pulse;

    int checks = 0;
    int fails  = 0;
    logic [31:0] selw [4];
    logic [31:0] rd;

    always #5 clk = ~clk;

    extint_ctrl dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_pins(pins), .irq_req(irq_req), .evt_pulse(evt_pulse)
    );

    // {line[15:12], port[11:10], rise[9], fall[8], falling_edge[7], expect[6], pad}
    localparam logic [15:0] VEC [8] = '{
        {4'd0,  2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0},
        {4'd3,  2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0},
        {4'd5,  2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0},
        {4'd7,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0},
        {4'd9,  2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 6'd0},
        {4'd12, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {4'd15, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0},
        {4'd10, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_sel(input int line, input logic [3:0] v);
        selw[line/4][4*(line%4) +: 4] = v;
        wr(8'(4*(line/4)), selw[line/4]);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < 4; w++) selw[w] = '0;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 'h20; a += 4) begin
            rdreg(8'(a), rd);
            chk("R1 reset register", rd, 32'h0);
        end
        chk("R1 irq_req after reset", 32'(irq_req), 32'h0);
        chk("R1 evt_pulse after reset", 32'(evt_pulse), 32'h0);

        // R3/R4 table of lines, ports and edge kinds
        wr(8'h10, 32'hFFFF);
        for (int v = 0; v < 8; v++) begin
            automatic int line  = int'(VEC[v][15:12]);
            automatic int port  = int'(VEC[v][11:10]);
            automatic int idx   = port * 16 + line;
            automatic logic fe  = VEC[v][7];
            automatic logic exp = VEC[v][6];
            set_sel(line, 4'(port));
            wr(8'h18, VEC[v][9] ? (32'h1 << line) : 32'h0);
            wr(8'h1C, VEC[v][8] ? (32'h1 << line) : 32'h0);
            pins[idx] = fe;
            cycles(2);
            wr(8'h20, 32'hFFFF);
            pins[idx] = ~fe;
            @(negedge clk);
            rdreg(8'h20, rd);
            chk($sformatf("R3/R4 table %0d pending", v), 32'(rd[line]), 32'(exp));
            chk($sformatf("R3/R4 table %0d irq_req", v), 32'(irq_req[line]), 32'(exp));
        end

        // R2 out-of-range source field reads constant 0
        set_sel(2, 4'd5);
        wr(8'h18, 32'h4);
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'hFFFF);
        pins[2] = 1'b1; pins[18] = 1'b1; pins[34] = 1'b1; pins[50] = 1'b1;
        cycles(2);
        rdreg(8'h20, rd);
        chk("R2 out-of-range source no trigger", 32'(rd[2]), 32'h0);
        rdreg(8'h00, rd);
        chk("R2 selector field readback", 32'(rd[11:8]), 32'h5);

        // R9 reselect between sources of different level
        pins[1] = 1'b0; pins[17] = 1'b1;
        wr(8'h18, 32'h2);
        wr(8'h1C, 32'h2);
        cycles(2);
        wr(8'h20, 32'hFFFF);
        set_sel(1, 4'd1);
        cycles(3);
        rdreg(8'h20, rd);
        chk("R9 no trigger on reselect", 32'(rd[1]), 32'h0);
        pins[17] = 1'b0;
        @(negedge clk);
        rdreg(8'h20, rd);
        chk("R2 new source drives line", 32'(rd[1]), 32'h1);

        // R5 interrupt enable gates pending and request
        wr(8'h10, 32'h0);
        wr(8'h18, 32'h100);
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'hFFFF);
        pins[8] = 1'b1;
        @(negedge clk);
        rdreg(8'h20, rd);
        chk("R5 no pending while disabled", 32'(rd[8]), 32'h0);
        chk("R5 no irq while disabled", 32'(irq_req[8]), 32'h0);
        pins[8] = 1'b0;
        wr(8'h10, 32'h100);
        pins[8] = 1'b1;
        @(negedge clk);
        chk("R5 irq raised", 32'(irq_req[8]), 32'h1);
        cycles(5);
        chk("R5 irq held", 32'(irq_req[8]), 32'h1);
        wr(8'h10, 32'h0);
        chk("R5 irq dropped with enable", 32'(irq_req[8]), 32'h0);
        rdreg(8'h20, rd);
        chk("R5 pending kept", 32'(rd[8]), 32'h1);

        // R6 event pulse
        wr(8'h14, 32'h10);
        wr(8'h18, 32'h10);
        wr(8'h20, 32'hFFFF);
        pins[4] = 1'b1;
        @(negedge clk);
        chk("R6 event pulse high", 32'(evt_pulse), 32'h10);
        @(negedge clk);
        chk("R6 event pulse one cycle", 32'(evt_pulse), 32'h0);
        rdreg(8'h20, rd);
        chk("R6 event leaves pending", 32'(rd[4]), 32'h0);
        wr(8'h14, 32'h0);

        // R7 / R8 pending clear rules
        wr(8'h10, 32'h40);
        wr(8'h18, 32'h40);
        wr(8'h1C, 32'h40);
        wr(8'h20, 32'hFFFF);
        pins[6] = 1'b1;
        @(negedge clk);
        wr(8'h20, 32'h0);
        rdreg(8'h20, rd);
        chk("R7 write zero keeps pending", 32'(rd[6]), 32'h1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h40;
        pins[6] = 1'b0;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rdreg(8'h20, rd);
        chk("R8 trigger beats clear", 32'(rd[6]), 32'h1);
        wr(8'h20, 32'h40);
        rdreg(8'h20, rd);
        chk("R7 write one clears", 32'(rd[6]), 32'h0);
        chk("R7 irq low after clear", 32'(irq_req[6]), 32'h0);

        // R10 map details
        wr(8'h10, 32'hFFFF_FFFF);
        rdreg(8'h10, rd);
        chk("R10 upper bits read zero", rd, 32'h0000_FFFF);
        wr(8'h24, 32'h0);
        rdreg(8'h24, rd);
        chk("R10 unmapped reads zero", rd, 32'h0);
        rdreg(8'h10, rd);
        chk("R10 unmapped write ignored", rd, 32'h0000_FFFF);
        wr(8'h20, 32'hFFFF);
        wr(8'h20, 32'hFFFF);
        rdreg(8'h20, rd);
        chk("R10 pending write never sets", rd, 32'h0);

        finish_run();
    end
endmodule